// File: doc/BRIEF.md
# Modulator Clock Generator and Bit Sampler

This block sits on the controller side of a one-bit sigma-delta link. It divides a fast system clock by a programmable even ratio to produce the modulator clock, which is driven out to the modulator. The modulator changes its data bit shortly after each rising edge of that clock. The block captures the returning bit at a programmable number of system clocks after that rising edge. The delay is chosen so that capture happens after the modulator's worst-case access time and while the bit is still held.

Each captured bit is presented in the system clock domain with a one-cycle valid pulse, once per modulator period. Downstream decimation filters consume this stream.

Both settings are taken only at a period boundary. A new ratio or delay therefore never shortens a phase of the clock already on the pin. With a 200 MHz system clock, ratios from 10 to 40 cover the usual 5 to 20 MHz modulator range. Every ratio has an exactly even duty cycle, which meets the tighter high-time and low-time limit that applies above 16 MHz.

Top module: `mclk_sampler_top`

## Requirements
- R1: While `rst` is high, `mod_clk_o` and `bit_vld_o` are low. After reset, no valid pulse appears before the first rising edge of `mod_clk_o`.
- R2: With an effective half period H, every modulator period has exactly H system clocks high followed by H system clocks low, so the period is 2H. H is `half_div_i`, with a value of 0 treated as 1.
- R3: `half_div_i` is taken only on the system clock edge where `mod_clk_o` rises. It is also taken during reset. A change made at any other time takes effect from the next rising edge.
- R4: The bit is captured from `mod_dat_i` on the D-th system clock edge after the edge where `mod_clk_o` rose. D is `sample_dly_i` clamped to the range 1 to 2H-1, taken at the same rising edge as H.
- R5: `bit_vld_o` is a single-cycle pulse, exactly one per modulator period. It rises one system clock after the capture edge. `bit_o` holds the captured value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_div_i | input | CNT_W | Half period of the modulator clock, in system clocks |
| sample_dly_i | input | CNT_W+1 | System clocks from the rising edge to the capture |
| mod_dat_i | input | 1 | Serial bit returning from the modulator |
| mod_clk_o | output | 1 | Generated modulator clock |
| bit_o | output | 1 | Last captured bit |
| bit_vld_o | output | 1 | One-cycle strobe marking a new captured bit |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the modulator data is stable across the capture edge. In hardware, a correctly chosen delay ensures this.

The stimulus changes the settings only just after a system clock edge, and often partway through a high or low phase, so that the boundary rule is exercised. It covers out-of-range delays and a zero half period so that the clamping is exercised. The stimulus drives the data line to the expected bit only in the single cycle that is sampled, and to its inverse in every other cycle. Any capture one edge early or one edge late therefore shows up as a wrong bit.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

  // Effective half period: zero would stall the divider, so it maps to one.
  function automatic int unsigned eff_half(input int unsigned h);
    return (h == 0) ? 1 : h;
  endfunction

  // Effective capture delay: at least one edge past the rise, and no later
  // than the last edge before the following rise.
  function automatic int unsigned eff_dly(input int unsigned d, input int unsigned h);
    int unsigned top;
    top = 2 * h - 1;
    if (d == 0) return 1;
    if (d > top) return top;
    return d;
  endfunction

endpackage

// File: rtl/mclk_div.sv
module mclk_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] half_div_i,
  output logic             mod_clk_o,
  output logic             rise_evt_o,
  output logic [CNT_W-1:0] half_nxt_o
);
  import mclk_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;
  logic             clk_q;
  logic             phase_end;

  assign half_nxt_o = CNT_W'(eff_half(32'(half_div_i)));
  assign phase_end  = (cnt_q == half_q - 1'b1);
  assign rise_evt_o = !clk_q && phase_end;
  assign mod_clk_o  = clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q  <= 1'b0;
      cnt_q  <= '0;
      half_q <= half_nxt_o;
    end else if (phase_end) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
      if (!clk_q) half_q <= half_nxt_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the half period only moves on the edge that starts a new period
  p_half_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rise_evt_o |=> $stable(half_q));

  // R2: the phase counter never passes the latched half period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < half_q);

  // R2: a rise is always followed by a high cycle
  p_rise_high_r2: assert property (@(posedge clk) disable iff (rst)
    rise_evt_o |=> mod_clk_o);

endmodule

// File: rtl/mclk_cap.sv
module mclk_cap #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_evt_i,
  input  logic [CNT_W-1:0] half_nxt_i,
  input  logic [CNT_W:0]   sample_dly_i,
  input  logic             mod_dat_i,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             sample_evt_o
);
  import mclk_pkg::*;

  localparam int SW = CNT_W + 1;

  logic [SW-1:0] since_q;
  logic [SW-1:0] dly_q;
  logic [SW-1:0] dly_nxt;
  logic          armed_q;
  logic          bit_q;
  logic          vld_q;

  assign dly_nxt      = SW'(eff_dly(32'(sample_dly_i), 32'(half_nxt_i)));
  assign sample_evt_o = armed_q && (since_q == dly_q);
  assign bit_o        = bit_q;
  assign bit_vld_o    = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      dly_q   <= SW'(1);
      armed_q <= 1'b0;
      bit_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= sample_evt_o;
      if (sample_evt_o) bit_q <= mod_dat_i;
      if (rise_evt_i) begin
        since_q <= SW'(1);
        dly_q   <= dly_nxt;
        armed_q <= 1'b1;
      end else if (since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  // R1: nothing is strobed before the first generated rising edge
  p_no_early_vld_r1: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !vld_q);

  // R5: the strobe lasts a single system clock
  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);

  // R4: capture never coincides with the rising edge itself
  p_no_edge_sample_r4: assert property (@(posedge clk) disable iff (rst)
    rise_evt_i |-> !sample_evt_o);

  // R5: the captured bit only moves when a strobe follows
  p_bit_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !sample_evt_o |=> $stable(bit_q));

endmodule

// File: rtl/mclk_sampler_top.sv
module mclk_sampler_top #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] half_div_i,
  input  logic [CNT_W:0]   sample_dly_i,
  input  logic             mod_dat_i,
  output logic             mod_clk_o,
  output logic             bit_o,
  output logic             bit_vld_o
);

  logic             rise_evt;
  logic [CNT_W-1:0] half_nxt;
  logic             sample_evt;

  mclk_div #(.CNT_W(CNT_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .half_div_i (half_div_i),
    .mod_clk_o  (mod_clk_o),
    .rise_evt_o (rise_evt),
    .half_nxt_o (half_nxt)
  );

  mclk_cap #(.CNT_W(CNT_W)) u_cap (
    .clk          (clk),
    .rst          (rst),
    .rise_evt_i   (rise_evt),
    .half_nxt_i   (half_nxt),
    .sample_dly_i (sample_dly_i),
    .mod_dat_i    (mod_dat_i),
    .bit_o        (bit_o),
    .bit_vld_o    (bit_vld_o),
    .sample_evt_o (sample_evt)
  );

  // R4: a capture is strobed on the very next system clock
  p_strobe_follows_r4: assert property (@(posedge clk) disable iff (rst)
    sample_evt |=> bit_vld_o);

endmodule

// File: tb/mclk_sampler_top_tb_top.sv
module mclk_sampler_top_tb_top;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] half_div_i = 8'd2;
  logic [CNT_W:0]   sample_dly_i = 9'd1;
  logic             mod_dat_i = 1'b0;
  logic             mod_clk_o;
  logic             bit_o;
  logic             bit_vld_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mclk_sampler_top #(.CNT_W(CNT_W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .half_div_i   (half_div_i),
    .sample_dly_i (sample_dly_i),
    .mod_dat_i    (mod_dat_i),
    .mod_clk_o    (mod_clk_o),
    .bit_o        (bit_o),
    .bit_vld_o    (bit_vld_o)
  );

  function automatic int bh(input int h);
    return (h < 1) ? 1 : h;
  endfunction

  function automatic int bd(input int d, input int h);
    if (d < 1) return 1;
    if (d > 2 * h - 1) return 2 * h - 1;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // scoreboard queue of expected bits
  bit exp_q[$];

  // model: drives the data line, pushes expectations, pops on strobes
  int  n = 0, hi_run = 0, lo_run = 0, cur_h = 1, cur_d = 1, vld_cnt = 0;
  int  prev_half = 2, prev_dly = 1;
  bit  prev_clk = 0, have_period = 0, cur_bit = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    if (rst) begin
      chk(mod_clk_o == 1'b0, "R1 clock low in reset", int'(mod_clk_o), 0);
      chk(bit_vld_o == 1'b0, "R1 strobe low in reset", int'(bit_vld_o), 0);
    end else begin
      if (mod_clk_o && !prev_clk) begin
        if (have_period) begin
          chk(hi_run == cur_h, "R2/R3 high run", hi_run, cur_h);
          chk(lo_run == cur_h, "R2/R3 low run", lo_run, cur_h);
          chk(vld_cnt == 1, "R5 strobes per period", vld_cnt, 1);
        end else begin
          chk(vld_cnt == 0, "R1 no strobe before first rise", vld_cnt, 0);
        end
        cur_h = bh(prev_half);
        cur_d = bd(prev_dly, cur_h);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cur_bit = lfsr[0];
        exp_q.push_back(cur_bit);
        have_period = 1;
        n = 0; hi_run = 0; lo_run = 0; vld_cnt = 0;
      end else begin
        n++;
      end
      if (mod_clk_o) hi_run++; else lo_run++;
      if (bit_vld_o) begin
        vld_cnt++;
        chk(n == cur_d, "R4 strobe position", n, cur_d);
        if (exp_q.size() > 0) begin
          bit e;
          e = exp_q.pop_front();
          chk(bit_o == e, "R4/R5 captured bit", int'(bit_o), int'(e));
        end else begin
          chk(0, "R5 unexpected strobe", 1, 0);
        end
      end
      mod_dat_i = (have_period && n == cur_d - 1) ? cur_bit : ~cur_bit;
    end
    prev_half = int'(half_div_i);
    prev_dly  = int'(sample_dly_i);
    prev_clk  = mod_clk_o;
  end

  task automatic apply(input int h, input int d, input int periods);
    @(posedge clk); #2;
    half_div_i   = CNT_W'(h);
    sample_dly_i = (CNT_W+1)'(d);
    repeat (periods) @(posedge mod_clk_o);
  endtask

  task automatic apply_mid(input int h, input int d, input int periods);
    @(posedge mod_clk_o);
    repeat (2) @(posedge clk);
    #2;
    half_div_i   = CNT_W'(h);
    sample_dly_i = (CNT_W+1)'(d);
    repeat (periods) @(posedge mod_clk_o);
  endtask

  initial begin
    repeat (6) @(posedge clk);
    #2 rst = 1'b0;
    apply(2, 1, 8);     // R2 smallest useful ratio
    apply(4, 3, 8);     // R4 mid-period capture
    apply(5, 9, 6);     // R4 latest legal capture
    apply(3, 0, 6);     // R4 zero delay clamps to 1
    apply(3, 60, 6);    // R4 large delay clamps to 2H-1
    apply(0, 5, 8);     // R2 zero half period treated as 1
    apply(10, 7, 4);    // R2 ratio of 20
    apply_mid(6, 4, 4); // R3 change while high
    apply_mid(3, 2, 4); // R3 change while high, shrink
    apply_mid(7, 12, 4);
    repeat (40) @(posedge clk);
    chk(exp_q.size() <= 1, "R5 pending expectations", exp_q.size(), 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule